// File: doc/BRIEF.md
# Instruction Header Decoder

This block sits at the front of an instruction pipeline. It examines the leading bytes of one instruction: two opcode bytes and, when the instruction has operands, a third byte that gives the operand modes. From these it reports which operation was fetched and what shape of operands it takes. Both operands are described by kind, access width, field size and byte offset, and the total instruction length lets the fetch unit find the start of the next instruction.

A header is presented as a three-byte window together with a valid strobe. The decoded result appears one clock later with its own one-cycle valid pulse, and it is held until the next header arrives. The decoder does not fetch operands and does not execute anything. It does not raise a trap either. It only flags a malformed encoding, and the surrounding logic decides what to do with it.

Operand slot A is described by the upper nibble of the mode byte, and its field comes first in the byte stream. Slot B is described by the lower nibble, and its field follows slot A. For an instruction with a destination, slot A is that destination. For an instruction with two sources, slot A is the first source.

Top module: `instr_hdr_decoder`

## Requirements
- R1: The opcode is assembled little-endian, with `inBytes[7:0]` as its low byte and `inBytes[15:8]` as its high byte. The mode byte is `inBytes[23:16]`. The result appears on the clock edge after the one that samples `inValid`, and `outValid` is high for exactly that one cycle. Outputs hold their values while no header arrives. After reset, `outValid` is 0 and every output is 0.
- R2: `opClass` codes are 0 = no operands, 1 = destination plus source, 2 = two sources, 3 = source only, 4 = destination only, 5 = unknown opcode. Opcodes 0x1000–0x100C and 0x4000 are class 1. Opcodes 0x2000, 0x2001 and 0x3004 are class 2. Opcodes 0x2002–0x2004, 0x3000 and 0x3002 are class 3. Opcode 0x3003 is class 4. Opcodes 0x3001, 0x3005 and 0xF000–0xF002 are class 0.
- R3: A class 0 instruction has length 2, both kinds are 0 (none), and both offsets and widths are 0. Its mode byte is ignored.
- R4: Each used mode nibble is decoded into a kind (1 = memory, 2 = register, 3 = immediate) and an access width in bytes. Codes 0–3 are memory with widths 8, 4, 2 and 1. Code 4 is a register with width 8. Codes 5–8 are immediates with widths 8, 4, 2 and 1. An unused slot reports kind 0 and width 0.
- R5: An operand field takes 8 bytes for memory, 1 byte for a register, and the width of the immediate for an immediate. The length of an operand instruction is 3 plus the sizes of the fields it uses.
- R6: The slot A field starts at byte offset 3. The slot B field starts at 3 plus the size of the slot A field. The offset of an unused slot is 0.
- R7: An opcode not listed in R2 reports class 5 and sets `illegal`.
- R8: A used mode nibble with a code above 8 sets `illegal`.
- R9: An immediate code in slot A of a class 1 or class 4 instruction sets `illegal`. Immediates are legal in both slots of a class 2 instruction and in slot B of a class 1 instruction.
- R10: A class 3 or class 4 instruction with a nonzero lower nibble sets `illegal`.
- R11: When `illegal` is set, the length, both kinds, both widths and both offsets are 0. The opcode and the class are still reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A header is present on `inBytes` |
| inBytes | input | 24 | Opcode low byte, opcode high byte, mode byte (bits 7:0, 15:8, 23:16) |
| outValid | output | 1 | One-cycle pulse: a decoded result is present |
| opcode | output | 16 | Decoded opcode |
| opClass | output | 3 | Operand shape code (R2) |
| opAKind | output | 2 | Slot A kind |
| opBKind | output | 2 | Slot B kind |
| opAWidth | output | 4 | Slot A access width in bytes |
| opBWidth | output | 4 | Slot B access width in bytes |
| opAOffset | output | 5 | Byte offset of the slot A field |
| opBOffset | output | 5 | Byte offset of the slot B field |
| instLen | output | 5 | Total instruction length in bytes |
| illegal | output | 1 | Malformed encoding |

## Verification
On every cycle, the assertions check the structural rules:
- a result appears only after a header was presented;
- an unknown opcode is always flagged;
- a flagged result carries zero length and no operands;
- a destination slot never holds an immediate;
- slot A always starts at byte 3;
- the length never exceeds the largest possible instruction.

The exact class for each opcode, the width and field size of each mode code, and the placement of slot B are shown only by the scoreboard scenarios. The same holds for the rule that a no-operand instruction ignores its mode byte, and for the rejection of a nonzero tail nibble. These scenarios compare every output field against a model built from the requirements.

// File: rtl/ihd_pkg.sv
package ihd_pkg;

  localparam int OPC_W     = 16;
  localparam int HDR_BYTES = 3;
  localparam int MODE_W    = 4;
  localparam int MAX_IMM   = 8;

  typedef enum logic [2:0] {
    CLS_NONE   = 3'd0,
    CLS_DSTSRC = 3'd1,
    CLS_SRCSRC = 3'd2,
    CLS_SRC    = 3'd3,
    CLS_DST    = 3'd4,
    CLS_BAD    = 3'd5
  } opClass_e;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_MEM  = 2'd1,
    KIND_REG  = 2'd2,
    KIND_IMM  = 2'd3
  } kind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;       // capture a new header this cycle
    logic known;      // opcode is recognised
    logic useA;       // slot A (upper nibble) carries an operand
    logic useB;       // slot B (lower nibble) carries an operand
    logic aIsDest;    // slot A is a destination
    logic tailZero;   // lower nibble must be zero
  } slotCtl_t;

endpackage

// File: rtl/ihd_ctrl.sv
module ihd_ctrl
  import ihd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [OPC_W-1:0] opcodeIn,
  output opClass_e         clsNext,
  output slotCtl_t         ctl,
  output logic             outValid
);

  // Opcode classification
  always_comb begin
    case (opcodeIn) inside
      [16'h1000:16'h100C], 16'h4000:          clsNext = CLS_DSTSRC;
      16'h2000, 16'h2001, 16'h3004:           clsNext = CLS_SRCSRC;
      [16'h2002:16'h2004], 16'h3000, 16'h3002: clsNext = CLS_SRC;
      16'h3003:                               clsNext = CLS_DST;
      16'h3001, 16'h3005, [16'hF000:16'hF002]: clsNext = CLS_NONE;
      default:                                clsNext = CLS_BAD;
    endcase
  end

  // Strobe generation
  always_comb begin
    ctl.load     = inValid;
    ctl.known    = (clsNext != CLS_BAD);
    ctl.useA     = (clsNext == CLS_DSTSRC) || (clsNext == CLS_SRCSRC) ||
                   (clsNext == CLS_SRC)    || (clsNext == CLS_DST);
    ctl.useB     = (clsNext == CLS_DSTSRC) || (clsNext == CLS_SRCSRC);
    ctl.aIsDest  = (clsNext == CLS_DSTSRC) || (clsNext == CLS_DST);
    ctl.tailZero = (clsNext == CLS_SRC)    || (clsNext == CLS_DST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/ihd_slot.sv
module ihd_slot
  import ihd_pkg::*;
#(
  parameter int ADDR_BYTES = 8,
  parameter int REG_BYTES  = 8,
  parameter int LEN_W      = 5,
  parameter int WID_W      = 4
) (
  input  logic [MODE_W-1:0] modeCode,
  output kind_e             kind,
  output logic [WID_W-1:0]  accBytes,
  output logic [LEN_W-1:0]  fieldLen,
  output logic              badCode
);

  logic [1:0] immIdx;
  assign immIdx = 2'(modeCode - MODE_W'(5));

  always_comb begin
    kind     = KIND_NONE;
    accBytes = '0;
    fieldLen = '0;
    badCode  = 1'b0;
    if (modeCode <= MODE_W'(3)) begin
      kind     = KIND_MEM;
      accBytes = WID_W'(MAX_IMM >> modeCode[1:0]);
      fieldLen = LEN_W'(ADDR_BYTES);
    end else if (modeCode == MODE_W'(4)) begin
      kind     = KIND_REG;
      accBytes = WID_W'(REG_BYTES);
      fieldLen = LEN_W'(1);
    end else if (modeCode <= MODE_W'(8)) begin
      kind     = KIND_IMM;
      accBytes = WID_W'(MAX_IMM >> immIdx);
      fieldLen = LEN_W'(MAX_IMM >> immIdx);
    end else begin
      badCode  = 1'b1;
    end
  end

endmodule

// File: rtl/ihd_dpath.sv
module ihd_dpath
  import ihd_pkg::*;
#(
  parameter int ADDR_BYTES = 8,
  parameter int REG_BYTES  = 8,
  parameter int LEN_W      = 5,
  parameter int WID_W      = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  slotCtl_t         ctl,
  input  opClass_e         clsNext,
  input  logic [OPC_W-1:0] opcodeIn,
  input  logic [7:0]       modeByte,
  output logic [OPC_W-1:0] opcode,
  output opClass_e         opClass,
  output kind_e            opAKind,
  output kind_e            opBKind,
  output logic [WID_W-1:0] opAWidth,
  output logic [WID_W-1:0] opBWidth,
  output logic [LEN_W-1:0] opAOffset,
  output logic [LEN_W-1:0] opBOffset,
  output logic [LEN_W-1:0] instLen,
  output logic             illegal
);

  localparam int NSLOT = 2;

  kind_e             sKind [NSLOT];
  logic [WID_W-1:0]  sAcc  [NSLOT];
  logic [LEN_W-1:0]  sLen  [NSLOT];
  logic              sBad  [NSLOT];

  // Slot 0 reads the upper nibble, slot 1 the lower nibble
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    ihd_slot #(
      .ADDR_BYTES(ADDR_BYTES), .REG_BYTES(REG_BYTES),
      .LEN_W(LEN_W), .WID_W(WID_W)
    ) u_slot (
      .modeCode(modeByte[(NSLOT-1-s)*MODE_W +: MODE_W]),
      .kind    (sKind[s]),
      .accBytes(sAcc[s]),
      .fieldLen(sLen[s]),
      .badCode (sBad[s])
    );
  end

  logic             aBad, bBad, illNext;
  kind_e            aKindN, bKindN;
  logic [WID_W-1:0] aWidN, bWidN;
  logic [LEN_W-1:0] aLenN, bLenN, aOffN, bOffN, lenN;

  always_comb begin
    aBad    = ctl.useA && (sBad[0] || (ctl.aIsDest && sKind[0] == KIND_IMM));
    bBad    = (ctl.useB && sBad[1]) ||
              (ctl.tailZero && modeByte[MODE_W-1:0] != '0);
    illNext = !ctl.known || aBad || bBad;

    aKindN = KIND_NONE; bKindN = KIND_NONE;
    aWidN  = '0;        bWidN  = '0;
    aLenN  = '0;        bLenN  = '0;
    aOffN  = '0;        bOffN  = '0;
    lenN   = '0;

    if (!illNext) begin
      if (ctl.useA) begin
        aKindN = sKind[0];
        aWidN  = sAcc[0];
        aLenN  = sLen[0];
        aOffN  = LEN_W'(HDR_BYTES);
      end
      if (ctl.useB) begin
        bKindN = sKind[1];
        bWidN  = sAcc[1];
        bLenN  = sLen[1];
        bOffN  = LEN_W'(HDR_BYTES) + aLenN;
      end
      lenN = ctl.useA ? LEN_W'(HDR_BYTES) + aLenN + bLenN
                      : LEN_W'(HDR_BYTES - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opcode    <= '0;
      opClass   <= CLS_NONE;
      opAKind   <= KIND_NONE;
      opBKind   <= KIND_NONE;
      opAWidth  <= '0;
      opBWidth  <= '0;
      opAOffset <= '0;
      opBOffset <= '0;
      instLen   <= '0;
      illegal   <= 1'b0;
    end else if (ctl.load) begin
      opcode    <= opcodeIn;
      opClass   <= clsNext;
      opAKind   <= aKindN;
      opBKind   <= bKindN;
      opAWidth  <= aWidN;
      opBWidth  <= bWidN;
      opAOffset <= aOffN;
      opBOffset <= bOffN;
      instLen   <= lenN;
      illegal   <= illNext;
    end
  end

endmodule

// File: rtl/instr_hdr_decoder.sv
module instr_hdr_decoder
  import ihd_pkg::*;
#(
  parameter int ADDR_BYTES = 8,
  parameter int REG_BYTES  = 8,
  localparam int MAX_FIELD = (ADDR_BYTES > MAX_IMM) ? ADDR_BYTES : MAX_IMM,
  localparam int MAX_WID   = (REG_BYTES > MAX_IMM) ? REG_BYTES : MAX_IMM,
  localparam int LEN_W     = $clog2(HDR_BYTES + 2*MAX_FIELD + 1),
  localparam int WID_W     = $clog2(MAX_WID + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic [HDR_BYTES*8-1:0] inBytes,
  output logic                   outValid,
  output logic [OPC_W-1:0]       opcode,
  output logic [2:0]             opClass,
  output logic [1:0]             opAKind,
  output logic [1:0]             opBKind,
  output logic [WID_W-1:0]       opAWidth,
  output logic [WID_W-1:0]       opBWidth,
  output logic [LEN_W-1:0]       opAOffset,
  output logic [LEN_W-1:0]       opBOffset,
  output logic [LEN_W-1:0]       instLen,
  output logic                   illegal
);

  slotCtl_t ctl;
  opClass_e clsNext, clsQ;
  kind_e    aKindQ, bKindQ;

  ihd_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .opcodeIn(inBytes[OPC_W-1:0]),
    .clsNext (clsNext),
    .ctl     (ctl),
    .outValid(outValid)
  );

  ihd_dpath #(
    .ADDR_BYTES(ADDR_BYTES), .REG_BYTES(REG_BYTES),
    .LEN_W(LEN_W), .WID_W(WID_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .clsNext  (clsNext),
    .opcodeIn (inBytes[OPC_W-1:0]),
    .modeByte (inBytes[OPC_W +: 8]),
    .opcode   (opcode),
    .opClass  (clsQ),
    .opAKind  (aKindQ),
    .opBKind  (bKindQ),
    .opAWidth (opAWidth),
    .opBWidth (opBWidth),
    .opAOffset(opAOffset),
    .opBOffset(opBOffset),
    .instLen  (instLen),
    .illegal  (illegal)
  );

  assign opClass = clsQ;
  assign opAKind = aKindQ;
  assign opBKind = bKindQ;

endmodule

// File: rtl/ihd_checker.sv
module ihd_checker #(
  parameter int LEN_W   = 5,
  parameter int WID_W   = 4,
  parameter int MAX_LEN = 19
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             outValid,
  input logic [2:0]       opClass,
  input logic [1:0]       opAKind,
  input logic [1:0]       opBKind,
  input logic [WID_W-1:0] opAWidth,
  input logic [LEN_W-1:0] opAOffset,
  input logic [LEN_W-1:0] opBOffset,
  input logic [LEN_W-1:0] instLen,
  input logic             illegal
);

  AST_RESULT_AFTER_HEADER: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid)); // R1

  AST_UNKNOWN_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && opClass == 3'd5) |-> illegal); // R7

  AST_ILLEGAL_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && illegal) |-> (instLen == '0 && opAKind == 2'd0 &&
                               opBKind == 2'd0 && opAOffset == '0 &&
                               opBOffset == '0)); // R11

  AST_NO_IMM_DEST: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && (opClass == 3'd1 || opClass == 3'd4)) |-> opAKind != 2'd3); // R9

  AST_SLOT_A_START: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && opAKind != 2'd0) |-> opAOffset == LEN_W'(3)); // R6

  AST_NONE_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && opClass == 3'd0) |-> (instLen == LEN_W'(2) &&
                                       opAWidth == '0)); // R3

  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> instLen <= LEN_W'(MAX_LEN)); // R5

endmodule

bind instr_hdr_decoder ihd_checker #(
  .LEN_W(LEN_W), .WID_W(WID_W), .MAX_LEN(ihd_pkg::HDR_BYTES + 2*MAX_FIELD)
) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .outValid(outValid),
  .opClass(opClass), .opAKind(opAKind), .opBKind(opBKind),
  .opAWidth(opAWidth), .opAOffset(opAOffset), .opBOffset(opBOffset),
  .instLen(instLen), .illegal(illegal)
);

// File: tb/instr_hdr_decoder_test.sv
module instr_hdr_decoder_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [23:0] inBytes = '0;
  logic        outValid;
  logic [15:0] opcode;
  logic [2:0]  opClass;
  logic [1:0]  opAKind, opBKind;
  logic [3:0]  opAWidth, opBWidth;
  logic [4:0]  opAOffset, opBOffset, instLen;
  logic        illegal;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk; // 125 MHz

  instr_hdr_decoder uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inBytes(inBytes),
    .outValid(outValid), .opcode(opcode), .opClass(opClass),
    .opAKind(opAKind), .opBKind(opBKind), .opAWidth(opAWidth),
    .opBWidth(opBWidth), .opAOffset(opAOffset), .opBOffset(opBOffset),
    .instLen(instLen), .illegal(illegal)
  );

  typedef struct {
    logic [15:0] opc;
    logic [2:0]  cls;
    logic [1:0]  ka, kb;
    logic [3:0]  wa, wb;
    logic [4:0]  oa, ob, len;
    logic        ill;
    string       tag;
  } exp_t;

  exp_t expQ[$];

  // Mode-code model (R4, R5)
  function automatic void nibModel(input logic [3:0] c, output logic [1:0] k,
                                   output logic [3:0] w, output logic [4:0] f,
                                   output logic bad);
    k = 0; w = 0; f = 0; bad = 0;
    case (c)
      4'd0: begin k = 1; w = 8; f = 8; end
      4'd1: begin k = 1; w = 4; f = 8; end
      4'd2: begin k = 1; w = 2; f = 8; end
      4'd3: begin k = 1; w = 1; f = 8; end
      4'd4: begin k = 2; w = 8; f = 1; end
      4'd5: begin k = 3; w = 8; f = 8; end
      4'd6: begin k = 3; w = 4; f = 4; end
      4'd7: begin k = 3; w = 2; f = 2; end
      4'd8: begin k = 3; w = 1; f = 1; end
      default: bad = 1;
    endcase
  endfunction

  function automatic exp_t model(input logic [15:0] opc, input logic [7:0] mb,
                                 input string tag);
    exp_t e;
    logic [1:0] ka, kb; logic [3:0] wa, wb; logic [4:0] fa, fb;
    logic ba, bb, useA, useB;
    e.opc = opc; e.tag = tag;
    if ((opc >= 16'h1000 && opc <= 16'h100C) || opc == 16'h4000) e.cls = 1;
    else if (opc == 16'h2000 || opc == 16'h2001 || opc == 16'h3004) e.cls = 2;
    else if ((opc >= 16'h2002 && opc <= 16'h2004) || opc == 16'h3000 ||
             opc == 16'h3002) e.cls = 3;
    else if (opc == 16'h3003) e.cls = 4;
    else if (opc == 16'h3001 || opc == 16'h3005 ||
             (opc >= 16'hF000 && opc <= 16'hF002)) e.cls = 0;
    else e.cls = 5;
    nibModel(mb[7:4], ka, wa, fa, ba);
    nibModel(mb[3:0], kb, wb, fb, bb);
    useA = (e.cls >= 1 && e.cls <= 4);
    useB = (e.cls == 1 || e.cls == 2);
    e.ill = (e.cls == 5) || (useA && ba) || (useB && bb) ||
            ((e.cls == 1 || e.cls == 4) && ka == 3) ||
            ((e.cls == 3 || e.cls == 4) && mb[3:0] != 0);
    e.ka = 0; e.kb = 0; e.wa = 0; e.wb = 0; e.oa = 0; e.ob = 0; e.len = 0;
    if (!e.ill) begin
      if (e.cls == 0) e.len = 2;
      else begin
        e.ka = ka; e.wa = wa; e.oa = 3;
        e.len = 5'd3 + fa;
        if (useB) begin
          e.kb = kb; e.wb = wb; e.ob = 5'd3 + fa;
          e.len = e.len + fb;
        end
      end
    end
    return e;
  endfunction

  task automatic send(input logic [15:0] opc, input logic [7:0] mb,
                      input string tag);
    @(negedge clk);
    inValid = 1'b1;
    inBytes = {mb, opc[15:8], opc[7:0]};
    expQ.push_back(model(opc, mb, tag));
    @(posedge clk);
    #1 inValid = 1'b0;
  endtask

  task automatic check(input bit ok, input string what, input string act,
                       input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%s expected=%s", what, act, exp);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        check(0, "R1 unexpected result", "outValid=1", "no result");
      end else begin
        exp_t e;
        bit ok;
        e = expQ.pop_front();
        ok = opcode == e.opc && opClass == e.cls && opAKind == e.ka &&
             opBKind == e.kb && opAWidth == e.wa && opBWidth == e.wb &&
             opAOffset == e.oa && opBOffset == e.ob && instLen == e.len &&
             illegal == e.ill;
        check(ok, e.tag,
          $sformatf("opc=%h cls=%0d k=%0d/%0d w=%0d/%0d off=%0d/%0d len=%0d ill=%0d",
            opcode, opClass, opAKind, opBKind, opAWidth, opBWidth,
            opAOffset, opBOffset, instLen, illegal),
          $sformatf("opc=%h cls=%0d k=%0d/%0d w=%0d/%0d off=%0d/%0d len=%0d ill=%0d",
            e.opc, e.cls, e.ka, e.kb, e.wa, e.wb, e.oa, e.ob, e.len, e.ill));
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(outValid == 0 && opcode == 0 && instLen == 0 && illegal == 0,
          "R1 reset state",
          $sformatf("v=%0d opc=%h len=%0d", outValid, opcode, instLen),
          "v=0 opc=0000 len=0");

    send(16'hF001, 8'hFF, "R3 nop ignores mode byte");
    send(16'hF000, 8'h00, "R3 halt");
    send(16'h3001, 8'h9A, "R3 ret");
    send(16'h1000, 8'h44, "R4 R5 R6 add reg,reg");
    send(16'h1000, 8'h05, "R5 R6 add mem64,imm64 max length");
    send(16'h1001, 8'h38, "R4 sub mem8,imm8");
    send(16'h4000, 8'h17, "R2 R4 mov mem32,imm16");
    send(16'h100C, 8'h26, "R2 last alu opcode mem16,imm32");
    send(16'h2000, 8'h65, "R9 cmpeq imm,imm legal");
    send(16'h3004, 8'h84, "R2 R6 int imm8,reg");
    send(16'h2002, 8'h60, "R2 jmp imm32");
    send(16'h3002, 8'h40, "R2 push reg");
    send(16'h3003, 8'h20, "R2 pop mem16");
    send(16'h3003, 8'h50, "R9 pop imm dest");
    send(16'h1000, 8'h54, "R9 add imm dest");
    send(16'h2003, 8'h41, "R10 jz nonzero tail");
    send(16'h3003, 8'h08, "R10 pop nonzero tail");
    send(16'h1005, 8'h94, "R8 R11 dest code 9");
    send(16'h2001, 8'h4F, "R8 cmplt src code 15");
    send(16'h100D, 8'h44, "R7 unknown opcode");
    send(16'h0000, 8'h00, "R7 zero opcode");
    send(16'h3006, 8'h40, "R7 R11 unknown opcode");

    repeat (3) @(negedge clk);
    check(outValid == 0 && opcode == 16'h3006 && opClass == 3'd5,
          "R1 hold while idle",
          $sformatf("v=%0d opc=%h cls=%0d", outValid, opcode, opClass),
          "v=0 opc=3006 cls=5");
    check(expQ.size() == 0, "R1 all results delivered",
          $sformatf("%0d pending", expQ.size()), "0 pending");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule